// File: doc/BRIEF.md
# Iterated Reconfigurable Logic Column

The block models one column of four identical reconfigurable two-input, one-output logic cells. The column is reused over several clock cycles: in each cycle it performs one pass, registers the four cell outputs, and feeds them back as the inputs of the next pass. One fixed column therefore computes a function that would otherwise need several columns chained one after another. A small adder or a bit counter, for example, becomes a schedule of passes.

Each cell takes a four-bit control code and looks it up in a shared sixteen-entry function table. The table returns the cell's two-input truth table. Two bits of the code are shared by all cells, and the other two are set per cell. The configuration of every pass is a separate word in an eight-entry configuration file. Each word carries the shared bits, the per-cell bits and the input multiplexer selects, so the wiring and the functions can change from one pass to the next. Fresh operands are taken from the data input only on the first pass. A pass count, a start pulse and a one-cycle done pulse frame each operation.

Top module: `icol_column`

## Requirements
- R1: During and after reset, `cell_out` is 0 and `done` is low, and every function table entry and configuration word reads as 0.
- R2: A cell with function number F and input lines a (first line) and b (second line) outputs bit (3 - 2a - b) of F. The output for inputs 00 is therefore the MSB, so F = 10 (1010) outputs NOT b.
- R3: A cell's control code is {per-cell bits, shared bits}, with the per-cell bits as the two MSBs. The code indexes a 16-entry table of 4-bit function numbers. A table entry is written when `tbl_we` is high, with `tbl_addr` as the code and `tbl_wdata` as the function number. All four cells read the same table.
- R4: A configuration word has the shared bits in [1:0]. Cell k uses the field starting at bit 2+8k: per-cell bits in [1:0] of that field, first-line select in [4:2] and second-line select in [7:5]. The shared bits apply to every cell.
- R5: On the first pass of an operation, each input line takes `data_in[sel]`. On every later pass, it takes the previous pass's `cell_out[sel mod 4]`, and the select MSB has no effect.
- R6: Pass k of an operation (counting from 0) uses configuration entry k. An entry is written when `cfg_we` is high, with `cfg_addr` as the index.
- R7: An operation with `iter_m1` = m runs m+1 passes, one per clock, and the accepting edge performs the first pass. `done` is high for exactly one cycle: the cycle after the edge of the last pass.
- R8: `cell_out` is registered and holds its value between operations. A `start` that arrives while an operation is running has no effect on that operation or on the outputs.
- R9: A `start` during the `done` cycle is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Function table write enable |
| tbl_addr | input | 4 | Control code to write |
| tbl_wdata | input | 4 | Function number for that code |
| cfg_we | input | 1 | Configuration file write enable |
| cfg_addr | input | 3 | Pass index to write |
| cfg_wdata | input | 34 | Configuration word for that pass |
| data_in | input | 8 | Operands, used on the first pass only |
| iter_m1 | input | 3 | Pass count minus one, sampled at start |
| start | input | 1 | Begin an operation when idle |
| done | output | 1 | One-cycle pulse after the last pass |
| cell_out | output | 4 | Registered cell outputs |

## Verification
The bench targets the truth-table bit order. A design with the order reversed would return 0 instead of 1 for inputs 00 under function 10. It also checks that the shared control bits reach every cell. A design that wired them per cell would give a mixed output pattern where all ones are expected. A rotation through the feedback path, with select values of 4 and up, shows whether the design ignores the select MSB on later passes, or wrongly reads external data there. Pass counts from 1 to 8, a start pulse sent mid-operation and a start in the done cycle test the pass counter. An off-by-one counter, or a design that restarts on a stray start, would move the done pulse off the expected cycle.

// File: rtl/icol_pkg.sv
package icol_pkg;

    // Cell output for a two-input truth table: inputs {a,b}=00 map to the MSB.
    function automatic logic truth_pick(input logic [3:0] fn, input logic a, input logic b);
        logic [1:0] idx;
        idx = {a, b};
        return fn[2'd3 - idx];
    endfunction

endpackage

// File: rtl/icol_func_table.sv
module icol_func_table #(
    parameter int CODE_W    = 4,
    parameter int FN_W      = 4,
    parameter int NUM_PORTS = 4,
    localparam int DEPTH    = 1 << CODE_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [CODE_W-1:0]           waddr,
    input  logic [FN_W-1:0]             wdata,
    input  logic [NUM_PORTS*CODE_W-1:0] raddr,
    output logic [NUM_PORTS*FN_W-1:0]   rdata
);

    logic [FN_W-1:0] mem_q [DEPTH];
    logic [FN_W-1:0] mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d[i];
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
        assign rdata[p*FN_W +: FN_W] = mem_q[raddr[p*CODE_W +: CODE_W]];
    end

endmodule

// File: rtl/icol_cfg_file.sv
module icol_cfg_file #(
    parameter int DEPTH  = 8,
    parameter int WORD_W = 34,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] word_q [DEPTH];
    logic [WORD_W-1:0] word_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            word_d[i] = word_q[i];
        end
        if (we) begin
            word_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) word_q[i] <= '0;
            else        word_q[i] <= word_d[i];
        end
    end

    assign rdata = word_q[raddr];

endmodule

// File: rtl/icol_cell.sv
module icol_cell
    import icol_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int NUM_CELLS = 4,
    localparam int SEL_W    = $clog2(DATA_W),
    localparam int FB_W     = $clog2(NUM_CELLS)
) (
    input  logic                 first_pass,
    input  logic [DATA_W-1:0]    ext_data,
    input  logic [NUM_CELLS-1:0] fb_data,
    input  logic [SEL_W-1:0]     sel_a,
    input  logic [SEL_W-1:0]     sel_b,
    input  logic [3:0]           fn,
    output logic                 y
);

    logic line_a;
    logic line_b;

    always_comb begin
        if (first_pass) begin
            line_a = ext_data[sel_a];
            line_b = ext_data[sel_b];
        end else begin
            line_a = fb_data[sel_a[FB_W-1:0]];
            line_b = fb_data[sel_b[FB_W-1:0]];
        end
        y = truth_pick(fn, line_a, line_b);
    end

endmodule

// File: rtl/icol_column.sv
module icol_column #(
    parameter int NUM_CELLS = 4,
    parameter int DATA_W    = 8,
    parameter int MAX_ITER  = 8,
    parameter int SHARED_W  = 2,
    parameter int LOCAL_W   = 2,
    localparam int SEL_W    = $clog2(DATA_W),
    localparam int ITER_W   = $clog2(MAX_ITER),
    localparam int CODE_W   = LOCAL_W + SHARED_W,
    localparam int FN_W     = 4,
    localparam int CELL_W   = LOCAL_W + 2 * SEL_W,
    localparam int CFG_W    = SHARED_W + NUM_CELLS * CELL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tbl_we,
    input  logic [CODE_W-1:0]    tbl_addr,
    input  logic [FN_W-1:0]      tbl_wdata,
    input  logic                 cfg_we,
    input  logic [ITER_W-1:0]    cfg_addr,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic [DATA_W-1:0]    data_in,
    input  logic [ITER_W-1:0]    iter_m1,
    input  logic                 start,
    output logic                 done,
    output logic [NUM_CELLS-1:0] cell_out
);

    typedef struct packed {
        logic                 run;
        logic [ITER_W-1:0]    idx;
        logic [ITER_W-1:0]    last;
        logic                 done;
        logic [NUM_CELLS-1:0] outv;
    } col_state_t;

    col_state_t state_q, state_d;

    logic                        accept;
    logic [ITER_W-1:0]           pass_idx;
    logic [ITER_W-1:0]           last_idx;
    logic [CFG_W-1:0]            cfg_word;
    logic [SHARED_W-1:0]         shared_bits;
    logic [NUM_CELLS*CODE_W-1:0] codes;
    logic [NUM_CELLS*FN_W-1:0]   fns;
    logic [NUM_CELLS-1:0]        cell_y;
    logic                        run_q;

    assign accept      = start & ~state_q.run;
    assign pass_idx    = accept ? '0 : state_q.idx;
    assign last_idx    = accept ? iter_m1 : state_q.last;
    assign shared_bits = cfg_word[SHARED_W-1:0];
    assign run_q       = state_q.run;

    icol_cfg_file #(
        .DEPTH  (MAX_ITER),
        .WORD_W (CFG_W)
    ) cfg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .waddr (cfg_addr),
        .wdata (cfg_wdata),
        .raddr (pass_idx),
        .rdata (cfg_word)
    );

    icol_func_table #(
        .CODE_W    (CODE_W),
        .FN_W      (FN_W),
        .NUM_PORTS (NUM_CELLS)
    ) tbl_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wdata (tbl_wdata),
        .raddr (codes),
        .rdata (fns)
    );

    for (genvar k = 0; k < NUM_CELLS; k++) begin : g_cell
        localparam int BASE = SHARED_W + k * CELL_W;
        logic [LOCAL_W-1:0] local_bits;
        logic [SEL_W-1:0]   sel_a;
        logic [SEL_W-1:0]   sel_b;

        assign local_bits = cfg_word[BASE +: LOCAL_W];
        assign sel_a      = cfg_word[BASE + LOCAL_W +: SEL_W];
        assign sel_b      = cfg_word[BASE + LOCAL_W + SEL_W +: SEL_W];
        assign codes[k*CODE_W +: CODE_W] = {local_bits, shared_bits};

        icol_cell #(
            .DATA_W    (DATA_W),
            .NUM_CELLS (NUM_CELLS)
        ) cell_i (
            .first_pass (accept),
            .ext_data   (data_in),
            .fb_data    (state_q.outv),
            .sel_a      (sel_a),
            .sel_b      (sel_b),
            .fn         (fns[k*FN_W +: FN_W]),
            .y          (cell_y[k])
        );
    end

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        if (accept) begin
            state_d.last = iter_m1;
        end
        if (accept || state_q.run) begin
            state_d.outv = cell_y;
            if (pass_idx == last_idx) begin
                state_d.run  = 1'b0;
                state_d.done = 1'b1;
            end else begin
                state_d.run = 1'b1;
                state_d.idx = pass_idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign done     = state_q.done;
    assign cell_out = state_q.outv;

endmodule

// File: rtl/icol_column_chk.sv
module icol_column_chk #(
    parameter int NUM_CELLS = 4,
    parameter int ITER_W    = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic [ITER_W-1:0]    iter_m1,
    input logic                 run,
    input logic                 done,
    input logic [NUM_CELLS-1:0] cell_out
);

    logic [ITER_W:0]   pass_cnt;
    logic [ITER_W-1:0] want_m1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_cnt <= '0;
            want_m1  <= '0;
        end else if (start && !run) begin
            pass_cnt <= 1;
            want_m1  <= iter_m1;
        end else if (run) begin
            pass_cnt <= pass_cnt + 1'b1;
        end
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    pass_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pass_cnt == {1'b0, want_m1} + 1'b1));

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !run);

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !start) |=> $stable(cell_out));

endmodule

bind icol_column icol_column_chk #(
    .NUM_CELLS (NUM_CELLS),
    .ITER_W    (ITER_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .iter_m1  (iter_m1),
    .run      (run_q),
    .done     (done),
    .cell_out (cell_out)
);

// File: tb/icol_column_tb.sv
module icol_column_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 1'b0;
    logic [3:0]  tbl_addr = '0;
    logic [3:0]  tbl_wdata = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [33:0] cfg_wdata = '0;
    logic [7:0]  data_in = '0;
    logic [2:0]  iter_m1 = '0;
    logic        start = 1'b0;
    logic        done;
    logic [3:0]  cell_out;

    always #5 clk = ~clk;

    icol_column dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tbl_we    (tbl_we),
        .tbl_addr  (tbl_addr),
        .tbl_wdata (tbl_wdata),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .data_in   (data_in),
        .iter_m1   (iter_m1),
        .start     (start),
        .done      (done),
        .cell_out  (cell_out)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    finished = 0;

    // Behavioural reference model
    int         m_tbl [16];
    logic [33:0] m_cfg [8];
    bit         m_busy = 0;
    int         m_pass = 0;
    int         m_last = 0;
    bit         m_done = 0;
    logic [3:0] m_out = '0;

    function automatic logic [3:0] model_pass(int entry, bit first, logic [7:0] din, logic [3:0] prev);
        logic [3:0] res;
        int shared_v;
        shared_v = int'(m_cfg[entry] & 34'h3);
        for (int k = 0; k < 4; k++) begin
            int fld, own, sa, sb, fnum, a, b;
            fld  = int'((m_cfg[entry] >> (2 + 8 * k)) & 34'hFF);
            own  = fld % 4;
            sa   = (fld / 4) % 8;
            sb   = (fld / 32) % 8;
            fnum = m_tbl[own * 4 + shared_v];
            a    = first ? int'(din[sa]) : int'(prev[sa % 4]);
            b    = first ? int'(din[sb]) : int'(prev[sb % 4]);
            res[k] = 1'((fnum >> (3 - (2 * a + b))) & 1);
        end
        return res;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_out = '0; m_pass = 0; m_last = 0;
            for (int i = 0; i < 16; i++) m_tbl[i] = 0;
            for (int i = 0; i < 8; i++) m_cfg[i] = '0;
        end else begin
            bit step;
            bit first;
            step  = 0;
            first = 0;
            m_done = 0;
            if (!m_busy && start) begin
                m_pass = 0; m_last = int'(iter_m1); step = 1; first = 1;
            end else if (m_busy) begin
                step = 1;
            end
            if (step) begin
                m_out = model_pass(m_pass, first, data_in, m_out);
                if (m_pass == m_last) begin
                    m_busy = 0; m_done = 1;
                end else begin
                    m_busy = 1; m_pass = m_pass + 1;
                end
            end
            if (tbl_we) m_tbl[tbl_addr] = int'(tbl_wdata);
            if (cfg_we) m_cfg[cfg_addr] = cfg_wdata;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!finished) begin
            n_cmp++;
            if (done !== m_done || cell_out !== m_out) begin
                n_bad++;
                $display("FAIL %s cycle compare: done=%b out=%b expected done=%b out=%b",
                         cur_req, done, cell_out, m_done, m_out);
            end
        end
    end

    task automatic check_val(string req, logic [3:0] act, logic [3:0] exp_v);
        n_cmp++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp_v);
        end
    endtask

    task automatic check_int(string req, int act, int exp_v);
        n_cmp++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic wr_tbl(int code, int fn);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = 4'(code); tbl_wdata = 4'(fn);
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic wr_cfg(int idx, logic [33:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(idx); cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [33:0] pack_cfg(int shared_v, int own [4], int sa [4], int sb [4]);
        logic [33:0] w;
        w = 34'(shared_v % 4);
        for (int k = 0; k < 4; k++) begin
            w |= 34'((own[k] % 4) + 4 * (sa[k] % 8) + 32 * (sb[k] % 8)) << (2 + 8 * k);
        end
        return w;
    endfunction

    // Starts an operation; returns the number of negedges until done is seen.
    task automatic run_op(logic [7:0] d, int n_m1, output int waited);
        @(negedge clk);
        data_in = d; iter_m1 = 3'(n_m1); start = 1'b1;
        waited = 0;
        forever begin
            @(negedge clk);
            start = 1'b0;
            waited++;
            if (done) break;
            if (waited > 20) break;
        end
    endtask

    function automatic int lcg(inout int s);
        s = s * 1103515245 + 12345;
        return (s >>> 8) & 32'h00FF_FFFF;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int w;
        int seed;
        int own [4];
        int sa [4];
        int sb [4];
        seed = 7;

        // R1: reset state
        repeat (3) @(negedge clk);
        check_val("R1 reset outputs", cell_out, 4'b0000);
        check_val("R1 reset done", {3'b000, done}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        run_op(8'hFF, 0, w);
        check_val("R1 cleared table gives function 0", cell_out, 4'b0000);

        // R2: bit order of the truth table, function 10 outputs NOT b
        cur_req = "R2";
        wr_tbl(0, 10);
        own = '{0, 0, 0, 0}; sa = '{0, 0, 0, 0}; sb = '{1, 1, 1, 1};
        wr_cfg(0, pack_cfg(0, own, sa, sb));
        run_op(8'h00, 0, w);
        check_val("R2 inputs 00 under function 10", cell_out, 4'hF);
        run_op(8'h02, 0, w);
        check_val("R2 inputs 01 under function 10", cell_out, 4'h0);
        run_op(8'h01, 0, w);
        check_val("R2 inputs 10 under function 10", cell_out, 4'hF);

        // R3 R4: shared bits reach every cell, per-cell bits are the code MSBs
        cur_req = "R4";
        wr_tbl(1, 15);
        wr_tbl(0, 0);
        wr_tbl(4, 15);
        wr_tbl(8, 0);
        wr_tbl(12, 15);
        own = '{0, 0, 0, 0};
        wr_cfg(0, pack_cfg(1, own, sa, sb));
        run_op(8'h00, 0, w);
        check_val("R4 shared bits select code 1 in all cells", cell_out, 4'hF);
        cur_req = "R3";
        own = '{0, 1, 2, 3};
        wr_cfg(0, pack_cfg(0, own, sa, sb));
        run_op(8'h00, 0, w);
        check_val("R3 per-cell bits as code MSBs", cell_out, 4'b1010);

        // R5 R6: feedback rotation with select MSB set on the second pass
        cur_req = "R5";
        wr_tbl(0, 3);
        own = '{0, 0, 0, 0}; sa = '{0, 1, 2, 3}; sb = '{0, 0, 0, 0};
        wr_cfg(0, pack_cfg(0, own, sa, sb));
        sa = '{5, 6, 7, 4};
        wr_cfg(1, pack_cfg(0, own, sa, sb));
        run_op(8'h01, 1, w);
        check_val("R5 rotation through feedback, select MSB ignored", cell_out, 4'b1000);
        cur_req = "R6";
        run_op(8'hF2, 0, w);
        check_val("R6 single pass uses entry 0 only", cell_out, 4'b0010);

        // R7: pass counts 1..8 and done timing
        cur_req = "R7";
        for (int c = 0; c < 16; c++) wr_tbl(c, lcg(seed) % 16);
        for (int e = 0; e < 8; e++) wr_cfg(e, {2'(lcg(seed)), 32'(lcg(seed)) ^ (32'(lcg(seed)) << 8)});
        for (int n = 0; n < 8; n++) begin
            run_op(8'(lcg(seed)), n, w);
            check_int("R7 done delay equals pass count", w, n + 1);
        end

        // R8: hold between operations, start while running ignored
        cur_req = "R8";
        repeat (5) @(negedge clk);
        @(negedge clk);
        data_in = 8'h5A; iter_m1 = 3'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        data_in = 8'hC3; iter_m1 = 3'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        w = 3;
        while (!done && w < 20) begin
            @(negedge clk);
            w++;
        end
        check_int("R8 stray start does not restart the operation", w, 6);
        repeat (4) @(negedge clk);

        // R9: start during the done cycle is accepted
        cur_req = "R9";
        run_op(8'h3C, 2, w);
        data_in = 8'h81; iter_m1 = 3'd3; start = 1'b1;
        w = 0;
        forever begin
            @(negedge clk);
            start = 1'b0;
            w++;
            if (done || w > 20) break;
        end
        check_int("R9 back-to-back operation completes on time", w, 4);

        // Mixed sweep with fresh tables and configurations
        cur_req = "R6";
        for (int r = 0; r < 30; r++) begin
            if (r % 5 == 0) begin
                for (int e = 0; e < 8; e++) wr_cfg(e, {2'(lcg(seed)), 32'(lcg(seed)) ^ (32'(lcg(seed)) << 8)});
                for (int c = 0; c < 16; c++) wr_tbl(c, lcg(seed) % 16);
            end
            run_op(8'(lcg(seed)), lcg(seed) % 8, w);
        end

        repeat (3) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule